// File: doc/BRIEF.md
# Serial Interrupt Line Host Sequencer

This block is the host end of a single shared, open-drain interrupt line. Peripherals use this line to report many parallel interrupt requests one after another. The block frames each transfer. It drives a start pulse whose low width can be set. It gives one clock of active-high drive and then releases the line. Next it steps through a set number of three-clock request frames and reads the line in the first clock of each. It ends with a stop pulse whose length tells every agent which start mode comes next.

The block has two start modes. In continuous mode the host opens each transfer itself, after a short idle gap. In quiet mode the host stays silent until a peripheral pulls the line low for one clock. The host then holds the line low from the very next clock, so the two pulses join into one start pulse. The request levels read during a transfer are collected in a shadow register. They are copied to the output vector in one step when the stop pulse begins.

The outputs are the two pad drive enables: one pulls the line low and one drives it high. The line level that feeds back in is the wired result of every agent on the line.

Top module: `serirq_host_ctrl`

## Requirements
- R1: During reset and after it, both drive enables are 0 and `irq_vec` is all ones. The block leaves reset in continuous mode and starts its first start pulse by itself, no more than two clocks after reset is released.
- R2: A start pulse begun by the host holds `drive_low` for 4 + `width_sel` clocks. For `width_sel` of 4 or more, this is limited to 8 clocks.
- R3: In quiet mode, when the idle host samples `line_in` = 0, it asserts `drive_low` on the next clock and holds it for the start length of R2 minus one. The peripheral's clock therefore counts toward the total.
- R4: The clock after a start pulse ends has `drive_high` = 1 for exactly one clock. After that, both enables are 0.
- R5: The number of active frames is `frame_cnt`, with 0 treated as 1 and values above `NFRAMES` treated as `NFRAMES`. Each frame lasts three clocks (sample, recovery, turnaround), and both enables stay 0 throughout. The stop pulse begins on the clock right after the last turnaround.
- R6: Bit i of `irq_vec` takes the level of `line_in` sampled at the end of the sample clock of frame i, where 1 means high (no request). Bits at or above the active frame count become 1.
- R7: `irq_vec` changes only on the first clock of a stop pulse. It holds its value at all other times.
- R8: The stop pulse holds `drive_low` for 2 clocks when `quiet_req` = 1 and for 3 clocks when `quiet_req` = 0. `quiet_req` is sampled at the end of the last frame, and that value becomes the mode for the next transfer. One clock of `drive_high` follows, then release.
- R9: In continuous mode the next start pulse begins after exactly `GAP_CLKS` + 1 released clocks following the stop pulse's high clock.
- R10: In quiet mode, while `line_in` stays high, the host keeps both enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sampled level of the shared line |
| quiet_req | input | 1 | Mode chosen at the end of each transfer: 1 = quiet, 0 = continuous |
| width_sel | input | WSEL_W | Start pulse width code (total low = 4 + code, at most 8) |
| frame_cnt | input | FCW | Number of request frames per transfer |
| drive_low | output | 1 | Pad enable that pulls the line low |
| drive_high | output | 1 | Pad enable that drives the line high |
| irq_vec | output | NFRAMES | Collected request levels, one bit per frame |

## Verification
A sequencer in the wrong state shows up at the drive enables within one clock. Examples are a start or stop pulse of the wrong length, a missing high clock, or drive during a frame. In each case the pulse edges fall on a clock other than the one computed from `width_sel`, `frame_cnt` and `quiet_req`. A wrong frame index or a bad shadow register shows up as a wrong bit of `irq_vec` on the first stop clock. An early commit shows up as a change of `irq_vec` in the middle of a transfer. The bench reads the enables on every clock of every transfer, so the first cycle that goes wrong is the one reported.

// File: rtl/serirq_host_pkg.sv
package serirq_host_pkg;

   localparam int MIN_LOW        = 4;
   localparam int MAX_LOW        = 8;
   localparam int STOP_QUIET_LEN = 2;
   localparam int STOP_CONT_LEN  = 3;
   localparam int FRAME_PHASES   = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_START_HI,
      ST_FRAME,
      ST_STOP,
      ST_STOP_HI,
      ST_GAP
   } sirq_state_e;

endpackage

// File: rtl/serirq_width_clamp.sv
module serirq_width_clamp #(
   parameter int WSEL_W  = 3,
   parameter int CNT_W   = 4,
   parameter int MIN_LOW = 4,
   parameter int MAX_LOW = 8
) (
   input  logic [WSEL_W-1:0] width_sel,
   output logic [CNT_W-1:0]  total_low
);

   localparam int RAW_MAX = (1 << WSEL_W) - 1 + MIN_LOW;

   if ((1 << CNT_W) <= MAX_LOW) begin : g_bad_cnt
      $error("serirq_width_clamp: CNT_W cannot hold MAX_LOW");
   end
   if (MIN_LOW > MAX_LOW) begin : g_bad_range
      $error("serirq_width_clamp: MIN_LOW above MAX_LOW");
   end

   if (RAW_MAX <= MAX_LOW) begin : g_direct
      assign total_low = CNT_W'(width_sel) + CNT_W'(MIN_LOW);
   end else begin : g_clamp
      always_comb begin
         if (int'(width_sel) + MIN_LOW > MAX_LOW)
            total_low = CNT_W'(MAX_LOW);
         else
            total_low = CNT_W'(width_sel) + CNT_W'(MIN_LOW);
      end
   end

endmodule

// File: rtl/serirq_frame_clamp.sv
module serirq_frame_clamp #(
   parameter int NFRAMES = 8,
   parameter int FCW     = 4,
   parameter int IDX_W   = 3
) (
   input  logic [FCW-1:0]   frame_cnt,
   output logic [IDX_W-1:0] last_idx
);

   if ((1 << FCW) <= NFRAMES) begin : g_bad_fcw
      $error("serirq_frame_clamp: FCW too narrow for NFRAMES");
   end

   always_comb begin
      if (frame_cnt == '0)
         last_idx = '0;
      else if (int'(frame_cnt) >= NFRAMES)
         last_idx = IDX_W'(NFRAMES - 1);
      else
         last_idx = IDX_W'(frame_cnt - FCW'(1));
   end

endmodule

// File: rtl/serirq_capture.sv
module serirq_capture #(
   parameter int NFRAMES = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               sample_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic               level,
   input  logic               commit,
   output logic [NFRAMES-1:0] irq_vec
);

   logic [NFRAMES-1:0] shadow;

   for (genvar i = 0; i < NFRAMES; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b1;
         else if (clear)
            bit_q <= 1'b1;
         else if (sample_en && (idx == IDX_W'(i)))
            bit_q <= level;
      end
      assign shadow[i] = bit_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_vec <= '1;
      else if (commit)
         irq_vec <= shadow;
   end

   // R7: the visible vector moves only on a commit
   p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(irq_vec));

   // R6: a clear never coincides with sampling or commit
   p_clear_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> (!sample_en && !commit));

endmodule

// File: rtl/serirq_host_ctrl.sv
module serirq_host_ctrl
   import serirq_host_pkg::*;
#(
   parameter int NFRAMES  = 8,
   parameter int WSEL_W   = 3,
   parameter int GAP_CLKS = 2,
   parameter int FCW      = $clog2(NFRAMES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_in,
   input  logic               quiet_req,
   input  logic [WSEL_W-1:0]  width_sel,
   input  logic [FCW-1:0]     frame_cnt,
   output logic               drive_low,
   output logic               drive_high,
   output logic [NFRAMES-1:0] irq_vec
);

   localparam int LOW_W = 4;
   localparam int GAP_W = $clog2(GAP_CLKS + 1);
   localparam int CW    = (GAP_W > LOW_W) ? GAP_W : LOW_W;
   localparam int IDX_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;
   localparam int RUN_W = LOW_W + 1;

   if (NFRAMES < 1) begin : g_bad_frames
      $error("serirq_host_ctrl: NFRAMES must be at least 1");
   end
   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("serirq_host_ctrl: GAP_CLKS must be at least 1");
   end
   if (WSEL_W < 1) begin : g_bad_wsel
      $error("serirq_host_ctrl: WSEL_W must be at least 1");
   end

   sirq_state_e       state;
   logic [CW-1:0]     cnt;
   logic [IDX_W-1:0]  idx;
   logic [1:0]        phase;
   logic              quiet_mode;
   logic [LOW_W-1:0]  total_low;
   logic [IDX_W-1:0]  last_idx;
   logic              last_turn;
   logic              sample_en;
   logic              clear_shadow;

   serirq_width_clamp #(
      .WSEL_W  (WSEL_W),
      .CNT_W   (LOW_W),
      .MIN_LOW (MIN_LOW),
      .MAX_LOW (MAX_LOW)
   ) i_width (
      .width_sel (width_sel),
      .total_low (total_low)
   );

   serirq_frame_clamp #(
      .NFRAMES (NFRAMES),
      .FCW     (FCW),
      .IDX_W   (IDX_W)
   ) i_frames (
      .frame_cnt (frame_cnt),
      .last_idx  (last_idx)
   );

   assign last_turn    = (state == ST_FRAME) && (phase == 2'd2) && (idx == last_idx);
   assign sample_en    = (state == ST_FRAME) && (phase == 2'd0);
   assign clear_shadow = (state == ST_START_HI);

   serirq_capture #(
      .NFRAMES (NFRAMES),
      .IDX_W   (IDX_W)
   ) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_shadow),
      .sample_en (sample_en),
      .idx       (idx),
      .level     (line_in),
      .commit    (last_turn),
      .irq_vec   (irq_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         idx        <= '0;
         phase      <= 2'd0;
         quiet_mode <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!quiet_mode) begin
                  state <= ST_START;
                  cnt   <= CW'(total_low) - CW'(1);
               end else if (!line_in) begin
                  state <= ST_START;
                  cnt   <= CW'(total_low) - CW'(2);
               end
            end
            ST_START: begin
               if (cnt == '0) state <= ST_START_HI;
               else           cnt   <= cnt - CW'(1);
            end
            ST_START_HI: begin
               state <= ST_FRAME;
               idx   <= '0;
               phase <= 2'd0;
            end
            ST_FRAME: begin
               if (phase == 2'(FRAME_PHASES - 1)) begin
                  phase <= 2'd0;
                  if (idx == last_idx) begin
                     state      <= ST_STOP;
                     quiet_mode <= quiet_req;
                     cnt        <= quiet_req ? CW'(STOP_QUIET_LEN - 1)
                                             : CW'(STOP_CONT_LEN - 1);
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end else begin
                  phase <= phase + 2'd1;
               end
            end
            ST_STOP: begin
               if (cnt == '0) state <= ST_STOP_HI;
               else           cnt   <= cnt - CW'(1);
            end
            ST_STOP_HI: begin
               state <= ST_GAP;
               cnt   <= CW'(GAP_CLKS - 1);
            end
            ST_GAP: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - CW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign drive_low  = (state == ST_START) || (state == ST_STOP);
   assign drive_high = (state == ST_START_HI) || (state == ST_STOP_HI);

   // run length of the low drive, used only by the checks below
   logic [RUN_W-1:0] low_run;
   always_ff @(posedge clk) begin
      if (!rst_n)
         low_run <= '0;
      else if (drive_low && (low_run != '1))
         low_run <= low_run + RUN_W'(1);
      else if (!drive_low)
         low_run <= '0;
   end

   // R2: no low pulse outlasts the widest start
   p_low_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |-> (low_run < RUN_W'(MAX_LOW)));

   // R3: a peripheral start seen in quiet idle is taken over next clock
   p_quiet_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && quiet_mode && !line_in) |=> drive_low);

   // R4: a high drive lasts one clock and is followed by release
   p_high_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drive_high |=> (!drive_high && !drive_low));

   // R9: continuous idle always launches a start
   p_cont_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !quiet_mode) |=> drive_low);

   // R10: quiet idle with a high line stays silent
   p_quiet_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && quiet_mode && line_in) |=> (!drive_low && !drive_high));

endmodule

// File: tb/test_serirq_host_ctrl.sv
module test_serirq_host_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NF         = 8;
   localparam int GAP        = 2;
   localparam int FCW        = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          periph_low = 1'b0;
   logic          quiet_req = 1'b0;
   logic [2:0]    width_sel = 3'd0;
   logic [FCW-1:0] frame_cnt = FCW'(NF);
   logic          drive_low;
   logic          drive_high;
   logic [NF-1:0] irq_vec;
   logic          line;

   int checks   = 0;
   int failures = 0;
   logic [NF-1:0] exp_vec = '1;

   assign line = drive_high ? 1'b1 : ~(drive_low | periph_low);

   always #(CLK_PERIOD / 2) clk = ~clk;

   serirq_host_ctrl #(
      .NFRAMES  (NF),
      .WSEL_W   (3),
      .GAP_CLKS (GAP),
      .FCW      (FCW)
   ) i_serirq_host_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (line),
      .quiet_req  (quiet_req),
      .width_sel  (width_sel),
      .frame_cnt  (frame_cnt),
      .drive_low  (drive_low),
      .drive_high (drive_high),
      .irq_vec    (irq_vec)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic do_cycle(input int w, input int n, input logic [NF-1:0] pat,
                           input bit q, input bit quiet_start, input int exp_gap);
      int T;
      int nc;
      int L;
      int idle;
      logic [NF-1:0] newv;
      width_sel = w[2:0];
      frame_cnt = n[FCW-1:0];
      quiet_req = q;
      T  = (w + 4 > 8) ? 8 : w + 4;
      nc = (n == 0) ? 1 : ((n > NF) ? NF : n);
      newv = '1;
      for (int i = 0; i < nc; i++) newv[i] = ~pat[i];

      if (quiet_start) begin
         for (int k = 0; k < 6; k++) begin
            tick;
            chk(!drive_low && !drive_high, "R10 quiet idle silent",
                int'(drive_low) + int'(drive_high), 0);
         end
         tick;
         periph_low = 1'b1;
         tick;
         periph_low = 1'b0;
         L = 0;
         while (drive_low && L < 20) begin L++; tick; end
         chk(L == T - 1, "R3 quiet takeover low length", L, T - 1);
      end else begin
         idle = 0;
         tick;
         while (!drive_low && idle < 40) begin idle++; tick; end
         if (exp_gap >= 0)
            chk(idle == exp_gap, "R9 continuous idle gap", idle, exp_gap);
         else
            chk(idle <= 1, "R1 autostart after reset", idle, 0);
         L = 0;
         while (drive_low && L < 20) begin L++; tick; end
         chk(L == T, "R2 start low length", L, T);
      end

      chk(drive_high, "R4 high clock after start", int'(drive_high), 1);

      for (int f = 0; f < nc; f++) begin
         for (int ph = 0; ph < 3; ph++) begin
            tick;
            chk(!drive_low && !drive_high, "R5 frame released",
                int'(drive_low) + int'(drive_high), 0);
            chk(irq_vec == exp_vec, "R7 vector held mid transfer",
                int'(irq_vec), int'(exp_vec));
            periph_low = (ph == 0) ? pat[f] : 1'b0;
         end
      end

      tick;
      periph_low = 1'b0;
      chk(drive_low, "R5 stop follows last frame", int'(drive_low), 1);
      chk(irq_vec == newv, "R6 vector at stop", int'(irq_vec), int'(newv));
      L = 0;
      while (drive_low && L < 20) begin L++; tick; end
      chk(L == (q ? 2 : 3), "R8 stop low length", L, q ? 2 : 3);
      chk(drive_high, "R8 high clock after stop", int'(drive_high), 1);
      exp_vec = newv;
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!drive_low && !drive_high, "R1 reset drives off",
          int'(drive_low) + int'(drive_high), 0);
      chk(irq_vec == '1, "R1 reset vector", int'(irq_vec), 255);
      rst_n = 1'b1;

      for (int w = 0; w < 8; w++)
         do_cycle(w, NF, 8'(w * 37 + 5), 1'b0, 1'b0, (w == 0) ? -1 : GAP + 1);

      do_cycle(5, 0,  8'hA5, 1'b0, 1'b0, GAP + 1);
      do_cycle(5, 1,  8'hFF, 1'b0, 1'b0, GAP + 1);
      do_cycle(5, 3,  8'h00, 1'b0, 1'b0, GAP + 1);
      do_cycle(5, 8,  8'h5A, 1'b0, 1'b0, GAP + 1);
      do_cycle(5, 15, 8'hC3, 1'b0, 1'b0, GAP + 1);

      do_cycle(2, 4, 8'h0F, 1'b1, 1'b0, GAP + 1);

      for (int w = 0; w < 8; w++)
         do_cycle(w, 6, 8'(w * 53 + 9), (w != 7), 1'b1, -1);

      do_cycle(0, NF, 8'h81, 1'b0, 1'b0, GAP + 1);

      finish_run;
   end

endmodule